// File: doc/BRIEF.md
# Data Bus Inversion Codec

This block sits between a core data path and an active-low, quad-pumped 64-bit parallel bus. Each bus clock carries four data beats (sub-phases), and the block handles all four side by side. On the transmit side it splits every beat into four 16-bit lanes. For each lane it counts the bits that would pull the wire low, which are the logical ones on an active-low bus. When that count is above half the lane width, it sends the lane complemented and raises the lane's inversion flag. Every lane of every beat is decided on its own.

On the receive side it takes the beats and flags seen on the bus and complements each flagged lane back. This recovers the original word. Both directions are registered, so results appear one clock after a valid beat is presented. A beat whose valid strobe is low produces the idle value: all data bits and flags clear, which leaves the wires released high.

Top module: `dbi_codec`

## Requirements
- R1: While reset is high and on the first edge after it, every data, flag and valid output is 0.
- R2: A transmit lane holding 9 or more logical ones (of 16) is output complemented, and its flag bit is 1. Lane n of beat b occupies data bits [b*64+n*16 +: 16] and flag bit b*4+n.
- R3: A transmit lane with exactly 8 or fewer ones is output unchanged, with its flag bit 0.
- R4: Each lane's decision depends only on that lane's bits. Neighbouring lanes with different weights in the same beat get different outcomes.
- R5: Each of the four beats in a clock is encoded independently of the others.
- R6: An output valid bit equals the matching input valid bit from one clock earlier, on both the transmit and receive sides.
- R7: The receive data equals the bus beat with each 16-bit lane XORed against its replicated flag bit. An encode followed by a decode returns the original word.
- R8: A beat presented with its valid bit low yields all-zero data and flags for that beat on the next clock, on both sides.
- R9: No valid encoded lane ever carries more than 8 logical ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_data_i | input | 256 | Four beats of 64-bit data to send, beat 0 in the low bits |
| tx_vld_i | input | 4 | Per-beat valid for transmit data |
| tx_data_o | output | 256 | Encoded beats for the bus |
| tx_flag_o | output | 16 | Per-lane inversion flags, 4 per beat |
| tx_vld_o | output | 4 | Per-beat valid for encoded data |
| rx_data_i | input | 256 | Four beats received from the bus |
| rx_flag_i | input | 16 | Inversion flags received with them |
| rx_vld_i | input | 4 | Per-beat valid for received data |
| rx_data_o | output | 256 | Restored data |
| rx_vld_o | output | 4 | Per-beat valid for restored data |

## Verification
The assertions take it as given that the valid strobes are clean 0/1 values whenever reset is low. They also take it as given that flag bits reaching the receive side belong to their own beat, since that side cannot judge whether a flag is plausible. The stimulus drives every input on the falling edge and holds it for a full clock. It lowers the valid bits between scenarios, so the idle checks on unused beats are always exercised against defined inputs.

// File: rtl/dbi_pkg.sv
package dbi_pkg;

  // Decide whether a lane is sent complemented: only a strict majority of
  // low-driven (logical one) bits triggers inversion.
  function automatic logic lane_needs_flip(input int unsigned weight,
                                           input int unsigned width);
    return (weight > (width / 2));
  endfunction

endpackage

// File: rtl/dbi_lane_enc.sv
module dbi_lane_enc #(
  parameter int LANE_W = 16
) (
  input  logic [LANE_W-1:0] raw,
  output logic [LANE_W-1:0] coded,
  output logic              flip
);
  import dbi_pkg::*;

  localparam int CNT_W = $clog2(LANE_W + 1);

  logic [CNT_W-1:0] weight;

  always_comb begin
    weight = '0;
    for (int i = 0; i < LANE_W; i++) begin
      weight = weight + CNT_W'(raw[i]);
    end
  end

  always_comb begin
    flip  = lane_needs_flip(int'(weight), LANE_W);
    coded = flip ? ~raw : raw;
  end

endmodule

// File: rtl/dbi_lane_dec.sv
module dbi_lane_dec #(
  parameter int LANE_W = 16
) (
  input  logic [LANE_W-1:0] coded,
  input  logic              flip,
  output logic [LANE_W-1:0] plain
);

  always_comb begin
    plain = coded ^ {LANE_W{flip}};
  end

endmodule

// File: rtl/dbi_codec.sv
module dbi_codec #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 16,
  parameter int BEATS  = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [BEATS*DATA_W-1:0]          tx_data_i,
  input  logic [BEATS-1:0]                 tx_vld_i,
  output logic [BEATS*DATA_W-1:0]          tx_data_o,
  output logic [BEATS*(DATA_W/LANE_W)-1:0] tx_flag_o,
  output logic [BEATS-1:0]                 tx_vld_o,
  input  logic [BEATS*DATA_W-1:0]          rx_data_i,
  input  logic [BEATS*(DATA_W/LANE_W)-1:0] rx_flag_i,
  input  logic [BEATS-1:0]                 rx_vld_i,
  output logic [BEATS*DATA_W-1:0]          rx_data_o,
  output logic [BEATS-1:0]                 rx_vld_o
);

  localparam int LANES = DATA_W / LANE_W;
  localparam int HALF  = LANE_W / 2;

  logic [BEATS*DATA_W-1:0] enc_word;
  logic [BEATS*LANES-1:0]  enc_flag;
  logic [BEATS*DATA_W-1:0] dec_word;

  for (genvar b = 0; b < BEATS; b++) begin : g_beat
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      localparam int LO = b*DATA_W + l*LANE_W;

      dbi_lane_enc #(.LANE_W(LANE_W)) u_enc (
        .raw   (tx_data_i[LO +: LANE_W]),
        .coded (enc_word[LO +: LANE_W]),
        .flip  (enc_flag[b*LANES + l])
      );

      dbi_lane_dec #(.LANE_W(LANE_W)) u_dec (
        .coded (rx_data_i[LO +: LANE_W]),
        .flip  (rx_flag_i[b*LANES + l]),
        .plain (dec_word[LO +: LANE_W])
      );

      AST_LANE_WEIGHT: assert property (@(posedge clk) disable iff (rst)
        tx_vld_o[b] |-> ($countones(tx_data_o[LO +: LANE_W]) <= HALF)); // R9
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        tx_data_o[b*DATA_W +: DATA_W] <= '0;
        tx_flag_o[b*LANES +: LANES]   <= '0;
        tx_vld_o[b]                   <= 1'b0;
        rx_data_o[b*DATA_W +: DATA_W] <= '0;
        rx_vld_o[b]                   <= 1'b0;
      end else begin
        tx_vld_o[b] <= tx_vld_i[b];
        rx_vld_o[b] <= rx_vld_i[b];
        if (tx_vld_i[b]) begin
          tx_data_o[b*DATA_W +: DATA_W] <= enc_word[b*DATA_W +: DATA_W];
          tx_flag_o[b*LANES +: LANES]   <= enc_flag[b*LANES +: LANES];
        end else begin
          tx_data_o[b*DATA_W +: DATA_W] <= '0;
          tx_flag_o[b*LANES +: LANES]   <= '0;
        end
        if (rx_vld_i[b]) begin
          rx_data_o[b*DATA_W +: DATA_W] <= dec_word[b*DATA_W +: DATA_W];
        end else begin
          rx_data_o[b*DATA_W +: DATA_W] <= '0;
        end
      end
    end

    AST_TX_LATENCY: assert property (@(posedge clk) disable iff (rst)
      tx_vld_i[b] |=> tx_vld_o[b]); // R6
    AST_RX_LATENCY: assert property (@(posedge clk) disable iff (rst)
      rx_vld_i[b] |=> rx_vld_o[b]); // R6
    AST_TX_IDLE: assert property (@(posedge clk) disable iff (rst)
      !tx_vld_i[b] |=> (tx_data_o[b*DATA_W +: DATA_W] == '0 &&
                        tx_flag_o[b*LANES +: LANES] == '0)); // R8
    AST_RX_IDLE: assert property (@(posedge clk) disable iff (rst)
      !rx_vld_i[b] |=> (rx_data_o[b*DATA_W +: DATA_W] == '0)); // R8
  end

endmodule

// File: tb/sim_dbi_codec.sv
module sim_dbi_codec;

  localparam int DW = 64;
  localparam int LW = 16;
  localparam int NB = 4;
  localparam int NL = DW / LW;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [NB*DW-1:0]    tx_data_i = '0;
  logic [NB-1:0]       tx_vld_i = '0;
  logic [NB*DW-1:0]    tx_data_o;
  logic [NB*NL-1:0]    tx_flag_o;
  logic [NB-1:0]       tx_vld_o;
  logic [NB*DW-1:0]    rx_data_i = '0;
  logic [NB*NL-1:0]    rx_flag_i = '0;
  logic [NB-1:0]       rx_vld_i = '0;
  logic [NB*DW-1:0]    rx_data_o;
  logic [NB-1:0]       rx_vld_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  dbi_codec u0 (
    .clk(clk), .rst(rst),
    .tx_data_i(tx_data_i), .tx_vld_i(tx_vld_i),
    .tx_data_o(tx_data_o), .tx_flag_o(tx_flag_o), .tx_vld_o(tx_vld_o),
    .rx_data_i(rx_data_i), .rx_flag_i(rx_flag_i), .rx_vld_i(rx_vld_i),
    .rx_data_o(rx_data_o), .rx_vld_o(rx_vld_o)
  );

  task automatic chk(input string req, input logic [NB*DW-1:0] act,
                     input logic [NB*DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] ones_low(input int k);
    logic [LW-1:0] v = '0;
    for (int i = 0; i < LW; i++) if (i < k) v[i] = 1'b1;
    return v;
  endfunction

  // Reference from the rules: invert when more than 8 of 16 bits are one.
  function automatic logic [NB*DW-1:0] ref_data(input logic [NB*DW-1:0] d,
                                                input logic [NB-1:0] v);
    logic [NB*DW-1:0] r = '0;
    for (int b = 0; b < NB; b++)
      for (int l = 0; l < NL; l++) begin
        logic [LW-1:0] s = d[b*DW + l*LW +: LW];
        int w = 0;
        for (int i = 0; i < LW; i++) w += int'(s[i]);
        if (v[b]) r[b*DW + l*LW +: LW] = (w > 8) ? ~s : s;
      end
    return r;
  endfunction

  function automatic logic [NB*NL-1:0] ref_flag(input logic [NB*DW-1:0] d,
                                                input logic [NB-1:0] v);
    logic [NB*NL-1:0] r = '0;
    for (int b = 0; b < NB; b++)
      for (int l = 0; l < NL; l++) begin
        int w = 0;
        for (int i = 0; i < LW; i++) w += int'(d[b*DW + l*LW + i]);
        if (v[b]) r[b*NL + l] = (w > 8);
      end
    return r;
  endfunction

  function automatic logic [NB*DW-1:0] rnd256();
    logic [NB*DW-1:0] r;
    for (int i = 0; i < 8; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  task automatic send_tx(input logic [NB*DW-1:0] d, input logic [NB-1:0] v,
                         input string req);
    @(negedge clk);
    tx_data_i = d; tx_vld_i = v;
    @(negedge clk);
    chk({req, " data"}, tx_data_o, ref_data(d, v));
    chk({req, " flag"}, 256'(tx_flag_o), 256'(ref_flag(d, v)));
    chk("R6 tx valid", 256'(tx_vld_o), 256'(v));
    tx_vld_i = '0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    tx_vld_i = '1; tx_data_i = '1; rx_vld_i = '1; rx_data_i = '1;
    @(negedge clk);
    chk("R1 tx data", tx_data_o, '0);
    chk("R1 flags/valid", 256'({tx_flag_o, tx_vld_o, rx_vld_o}), '0);
    chk("R1 rx data", rx_data_o, '0);
    tx_vld_i = '0; tx_data_i = '0; rx_vld_i = '0; rx_data_i = '0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", 256'({tx_flag_o, tx_vld_o, rx_vld_o}), '0);
  endtask

  task automatic t_boundary();
    int ks[4] = '{0, 8, 9, 16};
    foreach (ks[j]) begin
      logic [NB*DW-1:0] d = '0;
      for (int b = 0; b < NB; b++)
        for (int l = 0; l < NL; l++)
          d[b*DW + l*LW +: LW] = ones_low(ks[j]) << ((b + l) % 2) |
                                 ((ks[j] == 16) ? 16'hFFFF : 16'h0);
      if (ks[j] <= 8) send_tx(d, '1, "R3 weight<=8 unchanged");
      else            send_tx(d, '1, "R2 weight>=9 inverted");
    end
  endtask

  task automatic t_lanes();
    logic [NB*DW-1:0] d = '0;
    for (int b = 0; b < NB; b++)
      for (int l = 0; l < NL; l++)
        d[b*DW + l*LW +: LW] = ones_low(((b + l) % 4 == 0) ? 0 :
                                        ((b + l) % 4 == 1) ? 8 :
                                        ((b + l) % 4 == 2) ? 9 : 16);
    send_tx(d, '1, "R4 mixed lanes");
  endtask

  task automatic t_beats();
    logic [NB*DW-1:0] d = rnd256();
    d[0 +: DW]    = '1;
    d[DW +: DW]   = '0;
    send_tx(d, 4'b1010, "R8/R5 partial beats");
    send_tx(d, 4'b0101, "R5 other beats");
  endtask

  task automatic t_random();
    for (int it = 0; it < 24; it++) begin
      logic [NB*DW-1:0] d = rnd256();
      logic [NB*DW-1:0] cd;
      logic [NB*NL-1:0] cf;
      int worst = 0;
      send_tx(d, '1, "R2 random encode");
      cd = tx_data_o; cf = tx_flag_o;
      for (int g = 0; g < NB*NL; g++)
        if ($countones(cd[g*LW +: LW]) > worst) worst = $countones(cd[g*LW +: LW]);
      chk("R9 lane weight", 256'(worst > 8), '0);
      rx_data_i = cd; rx_flag_i = cf; rx_vld_i = '1;
      @(negedge clk);
      chk("R7 round trip", rx_data_o, d);
      chk("R6 rx valid", 256'(rx_vld_o), 256'(4'hF));
      rx_vld_i = '0;
    end
  endtask

  task automatic t_decode();
    logic [NB*DW-1:0] d = rnd256();
    logic [NB*NL-1:0] f = 16'hA53C;
    logic [NB*DW-1:0] e = '0;
    for (int b = 0; b < NB; b++)
      for (int l = 0; l < NL; l++)
        if (b != 2)
          e[b*DW + l*LW +: LW] = d[b*DW + l*LW +: LW] ^ {LW{f[b*NL + l]}};
    @(negedge clk);
    rx_data_i = d; rx_flag_i = f; rx_vld_i = 4'b1011;
    @(negedge clk);
    chk("R7/R8 direct decode", rx_data_o, e);
    chk("R6 rx valid partial", 256'(rx_vld_o), 256'(4'b1011));
    rx_vld_i = '0;
    @(negedge clk);
    chk("R8 rx idle", rx_data_o, '0);
  endtask

  initial begin
    t_reset();
    t_boundary();
    t_lanes();
    t_beats();
    t_random();
    t_decode();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog act=running exp=finished");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule